// File: doc/BRIEF.md
# Exception Entry Controller

This block is the exception-taking stage of a small 32-bit RISC core. The core presents a one-cycle request with four pieces of information: a class (ordinary exception, TLB refill miss, soft reset, non-maskable interrupt or debug), a 5-bit exception code, the PC of the faulting instruction, and a flag saying whether that instruction sat in a branch delay slot. On the next clock edge the block updates the privileged state it owns. That state is the exception-level, error-level and boot-vector status bits, the reset-source bits, the user-mode and debug-mode flags, the cause register's code field and delay-slot bit, and the three return-address registers (normal, error and debug). In the same edge it emits the address the fetch unit must jump to, qualified by a one-cycle strobe.

The error-level bit is driven out continuously. The MMU uses it to let low kernel addresses bypass translation. The core's coprocessor-write path can load the status bits through a small write port. An exception request in the same cycle has priority over that write.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `redirect_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise.
- R2: A class-0 or class-1 request taken while `exl_o` is 0 loads `epc_o` with `req_pc` and clears cause bit 31, or loads `req_pc`−4 and sets cause bit 31 when `req_in_slot` is 1.
- R3: A class-0 or class-1 request taken while `exl_o` is 1 leaves `epc_o` and cause bit 31 unchanged.
- R4: A class-0 or class-1 request sets `exl_o` and clears `user_o`. It writes `req_code` into cause bits 6:2, and all other cause bits keep their value.
- R5: For class 0 the redirect address is base + 0x180. The base is 0xBFC00200 when `bev_o` is 1 and 0x80000000 when it is 0.
- R6: A class-1 (refill) request uses offset 0x000 when `exl_o` is 0 and offset 0x180 when it is 1.
- R7: A class-0 request with code 0 (interrupt) uses offset 0x380 when `cfg_irq_vec` is 1, and 0x180 otherwise.
- R8: Class 2 (soft reset) and class 3 (NMI) load `error_epc_o` with the PC (or PC−4 in a slot). They set `erl_o` and `bev_o`, set `sr_o` or `nmi_o` respectively, clear `user_o`, and redirect to 0xBFC00000. Class 2 alone raises `watch_clr_o` for exactly one cycle.
- R9: Class 4 (debug) loads `depc_o` with the PC (or PC−4 in a slot), sets `debug_o`, clears `user_o`, and redirects to 0xBFC00480.
- R10: With `sw_we` high and no request, the next cycle shows `sw_exl`, `sw_erl`, `sw_bev` and `sw_um` on `exl_o`, `erl_o`, `bev_o` and `user_o`. A request in the same cycle wins, and the write is ignored.
- R11: After reset: `exl_o`=0, `erl_o`=1, `bev_o`=1, `user_o`=0, `debug_o`=0, `cause_o`=0, `epc_o`=0, `redirect_valid`=0.
- R12: Classes 2, 3 and 4 leave `epc_o` and `cause_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 3 | Class: 0 general, 1 refill, 2 soft reset, 3 NMI, 4 debug |
| req_code | input | 5 | Exception code for cause bits 6:2 |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_slot | input | 1 | Faulting instruction is in a branch delay slot |
| cfg_irq_vec | input | 1 | Selects the separate interrupt offset 0x380 |
| sw_we | input | 1 | Status write enable |
| sw_exl | input | 1 | Value written to exception level |
| sw_erl | input | 1 | Value written to error level |
| sw_bev | input | 1 | Value written to boot-vector select |
| sw_um | input | 1 | Value written to user mode |
| redirect_valid | output | 1 | Redirect strobe |
| redirect_pc | output | 32 | Vector address |
| exl_o | output | 1 | Exception level |
| erl_o | output | 1 | Error level (translation bypass for MMU) |
| bev_o | output | 1 | Boot-vector select |
| sr_o | output | 1 | Soft-reset source bit |
| nmi_o | output | 1 | NMI source bit |
| user_o | output | 1 | User mode |
| debug_o | output | 1 | Debug mode |
| cause_o | output | 32 | Cause register (bit 31 delay slot, 6:2 code) |
| epc_o | output | 32 | Exception return address |
| error_epc_o | output | 32 | Error return address |
| depc_o | output | 32 | Debug return address |
| watch_clr_o | output | 1 | Watch register clear strobe |

## Verification
If the exception-level bit is wrong, the fault shows up on the next request, in two places. `epc_o` is overwritten on a nested entry, or kept when it should be loaded, and a refill vector lands 0x180 away from its expected address. A wrong boot-vector bit moves every general vector by 0x3FC00200 in the cycle after the request. A stale return-address or delay-slot result is visible on the register outputs one edge after entry. The bench therefore samples every port in the single cycle after each request, and again one cycle later to confirm the strobe has dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XW = 32;
  localparam int CW = 5;
  localparam int OW = 12;

  typedef enum logic [2:0] {
    K_GEN    = 3'd0,
    K_REFILL = 3'd1,
    K_SRST   = 3'd2,
    K_NMI    = 3'd3,
    K_DBG    = 3'd4
  } exc_kind_e;

  localparam logic [XW-1:0] VEC_BOOT_GEN = 32'hBFC0_0200;
  localparam logic [XW-1:0] VEC_RAM_GEN  = 32'h8000_0000;
  localparam logic [XW-1:0] VEC_RESET    = 32'hBFC0_0000;
  localparam logic [XW-1:0] VEC_DEBUG    = 32'hBFC0_0480;
  localparam logic [OW-1:0] OFF_REFILL   = 12'h000;
  localparam logic [OW-1:0] OFF_GEN      = 12'h180;
  localparam logic [OW-1:0] OFF_IRQ      = 12'h380;
  localparam logic [CW-1:0] CODE_IRQ     = 5'd0;

  // Return address: step back over the branch when the fault sat in its slot.
  function automatic logic [XW-1:0] ret_addr(input logic [XW-1:0] pc,
                                             input logic slot,
                                             input logic [XW-1:0] step);
    return slot ? (pc - step) : pc;
  endfunction

  // Offset inside the general vector region.
  function automatic logic [OW-1:0] gen_offset(input logic refill,
                                               input logic exl,
                                               input logic [CW-1:0] code,
                                               input logic iv);
    logic [OW-1:0] off;
    off = OFF_GEN;
    if (refill && !exl)              off = OFF_REFILL;
    else if (!refill && iv && code == CODE_IRQ) off = OFF_IRQ;
    return off;
  endfunction

  function automatic logic [XW-1:0] gen_vector(input logic bev,
                                               input logic [OW-1:0] off);
    return (bev ? VEC_BOOT_GEN : VEC_RAM_GEN) + {{(XW-OW){1'b0}}, off};
  endfunction
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  output logic       ev_gen,
  output logic       ev_refill,
  output logic       ev_srst,
  output logic       ev_nmi,
  output logic       ev_dbg
);
  always_comb begin
    ev_gen    = 1'b0;
    ev_refill = 1'b0;
    ev_srst   = 1'b0;
    ev_nmi    = 1'b0;
    ev_dbg    = 1'b0;
    if (req_valid) begin
      case (exc_kind_e'(req_kind))
        K_REFILL: begin ev_gen = 1'b1; ev_refill = 1'b1; end
        K_SRST:   ev_srst = 1'b1;
        K_NMI:    ev_nmi  = 1'b1;
        K_DBG:    ev_dbg  = 1'b1;
        default:  ev_gen  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
(
  input  logic          ev_gen,
  input  logic          ev_refill,
  input  logic          ev_err,
  input  logic          ev_dbg,
  input  logic          exl,
  input  logic          bev,
  input  logic [CW-1:0] code,
  input  logic          cfg_irq_vec,
  output logic [XW-1:0] vec
);
  logic [OW-1:0] off;

  always_comb begin
    off = gen_offset(ev_refill, exl, code, cfg_irq_vec);
    vec = '0;
    if (ev_dbg)       vec = VEC_DEBUG;
    else if (ev_err)  vec = VEC_RESET;
    else if (ev_gen)  vec = gen_vector(bev, off);
  end
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
  import exc_entry_pkg::*;
#(
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_gen,
  input  logic          ev_err,
  input  logic          ev_dbg,
  input  logic          exl,
  input  logic [XW-1:0] pc,
  input  logic          slot,
  output logic [XW-1:0] epc,
  output logic [XW-1:0] error_epc,
  output logic [XW-1:0] depc,
  output logic          bd
);
  localparam logic [XW-1:0] STEP_W = XW'(STEP);
  logic [XW-1:0] ra;

  assign ra = ret_addr(pc, slot, STEP_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc       <= '0;
      error_epc <= '0;
      depc      <= '0;
      bd        <= 1'b0;
    end else begin
      if (ev_gen && !exl) begin
        epc <= ra;
        bd  <= slot;
      end
      if (ev_err) error_epc <= ra;
      if (ev_dbg) depc      <= ra;
    end
  end
endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_entry_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_gen,
  input  logic          ev_srst,
  input  logic          ev_nmi,
  input  logic          ev_dbg,
  input  logic [CW-1:0] code_in,
  input  logic          sw_we,
  input  logic          sw_exl,
  input  logic          sw_erl,
  input  logic          sw_bev,
  input  logic          sw_um,
  output logic          exl,
  output logic          erl,
  output logic          bev,
  output logic          sr,
  output logic          nmi,
  output logic          um,
  output logic          dm,
  output logic [CW-1:0] code
);
  logic any_ev;
  assign any_ev = ev_gen | ev_srst | ev_nmi | ev_dbg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exl  <= 1'b0;
      erl  <= 1'b1;
      bev  <= 1'b1;
      sr   <= 1'b0;
      nmi  <= 1'b0;
      um   <= 1'b0;
      dm   <= 1'b0;
      code <= '0;
    end else if (any_ev) begin
      um <= 1'b0;
      if (ev_gen) begin
        exl  <= 1'b1;
        code <= code_in;
      end
      if (ev_srst || ev_nmi) begin
        erl <= 1'b1;
        bev <= 1'b1;
      end
      if (ev_srst) sr  <= 1'b1;
      if (ev_nmi)  nmi <= 1'b1;
      if (ev_dbg)  dm  <= 1'b1;
    end else if (sw_we) begin
      exl <= sw_exl;
      erl <= sw_erl;
      bev <= sw_bev;
      um  <= sw_um;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [CW-1:0] req_code,
  input  logic [XW-1:0] req_pc,
  input  logic          req_in_slot,
  input  logic          cfg_irq_vec,
  input  logic          sw_we,
  input  logic          sw_exl,
  input  logic          sw_erl,
  input  logic          sw_bev,
  input  logic          sw_um,
  output logic          redirect_valid,
  output logic [XW-1:0] redirect_pc,
  output logic          exl_o,
  output logic          erl_o,
  output logic          bev_o,
  output logic          sr_o,
  output logic          nmi_o,
  output logic          user_o,
  output logic          debug_o,
  output logic [XW-1:0] cause_o,
  output logic [XW-1:0] epc_o,
  output logic [XW-1:0] error_epc_o,
  output logic [XW-1:0] depc_o,
  output logic          watch_clr_o
);
  // Named internal events, also watched by the checker.
  logic ev_gen, ev_refill, ev_srst, ev_nmi, ev_dbg, ev_err;
  logic [XW-1:0] vec_next;
  logic          bd;
  logic [CW-1:0] code_q;

  exc_classify u_cls (
    .req_valid (req_valid), .req_kind (req_kind),
    .ev_gen (ev_gen), .ev_refill (ev_refill), .ev_srst (ev_srst),
    .ev_nmi (ev_nmi), .ev_dbg (ev_dbg)
  );

  assign ev_err = ev_srst | ev_nmi;

  exc_vector_gen u_vec (
    .ev_gen (ev_gen), .ev_refill (ev_refill), .ev_err (ev_err), .ev_dbg (ev_dbg),
    .exl (exl_o), .bev (bev_o), .code (req_code), .cfg_irq_vec (cfg_irq_vec),
    .vec (vec_next)
  );

  exc_addr_regs #(.STEP(INSN_BYTES)) u_addr (
    .clk (clk), .rst_n (rst_n), .ev_gen (ev_gen), .ev_err (ev_err), .ev_dbg (ev_dbg),
    .exl (exl_o), .pc (req_pc), .slot (req_in_slot),
    .epc (epc_o), .error_epc (error_epc_o), .depc (depc_o), .bd (bd)
  );

  exc_status_regs u_st (
    .clk (clk), .rst_n (rst_n), .ev_gen (ev_gen), .ev_srst (ev_srst),
    .ev_nmi (ev_nmi), .ev_dbg (ev_dbg), .code_in (req_code),
    .sw_we (sw_we), .sw_exl (sw_exl), .sw_erl (sw_erl), .sw_bev (sw_bev), .sw_um (sw_um),
    .exl (exl_o), .erl (erl_o), .bev (bev_o), .sr (sr_o), .nmi (nmi_o),
    .um (user_o), .dm (debug_o), .code (code_q)
  );

  // Cause layout: bit 31 delay slot, bits 6:2 code; other bits are never written.
  assign cause_o = {bd, {(XW-CW-3){1'b0}}, code_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      watch_clr_o    <= 1'b0;
    end else begin
      redirect_valid <= req_valid;
      watch_clr_o    <= ev_srst;
      if (req_valid) redirect_pc <= vec_next;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          ev_gen,
  input logic          ev_srst,
  input logic          ev_err,
  input logic          ev_dbg,
  input logic          exl_o,
  input logic          erl_o,
  input logic          bev_o,
  input logic          user_o,
  input logic          debug_o,
  input logic          redirect_valid,
  input logic [XW-1:0] redirect_pc,
  input logic [XW-1:0] epc_o,
  input logic [XW-1:0] cause_o,
  input logic          watch_clr_o
);
  assert_redirect_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> redirect_valid);
  assert_redirect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !redirect_valid);
  assert_nested_keeps_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_gen && exl_o) |=> ($stable(epc_o) && $stable(cause_o[31])));
  assert_entry_kernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gen |=> (exl_o && !user_o));
  assert_cause_other_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gen |=> (cause_o[1:0] == $past(cause_o[1:0]) && cause_o[30:7] == $past(cause_o[30:7])));
  assert_error_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (erl_o && bev_o && !user_o && redirect_pc == VEC_RESET));
  assert_watch_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_srst |=> watch_clr_o);
  assert_watch_only_srst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_srst |=> !watch_clr_o);
  assert_debug_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dbg |=> (debug_o && !user_o && redirect_pc == VEC_DEBUG));
  assert_side_paths_keep_epc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err || ev_dbg) |=> ($stable(epc_o) && $stable(cause_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .ev_gen (ev_gen),
  .ev_srst (ev_srst), .ev_err (ev_err), .ev_dbg (ev_dbg), .exl_o (exl_o),
  .erl_o (erl_o), .bev_o (bev_o), .user_o (user_o), .debug_o (debug_o),
  .redirect_valid (redirect_valid), .redirect_pc (redirect_pc), .epc_o (epc_o),
  .cause_o (cause_o), .watch_clr_o (watch_clr_o)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_in_slot = 0, cfg_irq_vec = 0;
  logic [2:0] req_kind = 0;
  logic [4:0] req_code = 0;
  logic [31:0] req_pc = 0;
  logic sw_we = 0, sw_exl = 0, sw_erl = 0, sw_bev = 0, sw_um = 0;
  logic redirect_valid, exl_o, erl_o, bev_o, sr_o, nmi_o, user_o, debug_o, watch_clr_o;
  logic [31:0] redirect_pc, cause_o, epc_o, error_epc_o, depc_o;
  int checks = 0, errors = 0;
  logic [31:0] keep_epc, keep_cause;

  always #5 clk = ~clk;

  exc_entry_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic e, input logic r, input logic b, input logic u);
    @(negedge clk);
    sw_we = 1; sw_exl = e; sw_erl = r; sw_bev = b; sw_um = u;
    @(negedge clk);
    sw_we = 0;
  endtask

  // Request at a negedge; on return the design has taken it at the posedge in between.
  task automatic raise(input logic [2:0] k, input logic [4:0] c, input logic [31:0] pc,
                       input logic slot);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_code = c; req_pc = pc; req_in_slot = slot;
    @(negedge clk);
    req_valid = 0; req_in_slot = 0;
  endtask

  task automatic t_reset;
    chk("R11 exl", 32'(exl_o), 0);
    chk("R11 erl", 32'(erl_o), 1);
    chk("R11 bev", 32'(bev_o), 1);
    chk("R11 user", 32'(user_o), 0);
    chk("R11 debug", 32'(debug_o), 0);
    chk("R11 cause", cause_o, 0);
    chk("R11 epc", epc_o, 0);
    chk("R11 redirect", 32'(redirect_valid), 0);
  endtask

  task automatic t_status_write;
    sw_write(0, 0, 1, 1);
    chk("R10 exl", 32'(exl_o), 0);
    chk("R10 erl", 32'(erl_o), 0);
    chk("R10 bev", 32'(bev_o), 1);
    chk("R10 user", 32'(user_o), 1);
  endtask

  task automatic t_first_entry;
    raise(3'd0, 5'd4, 32'h0000_1000, 1);
    chk("R1 strobe", 32'(redirect_valid), 1);
    chk("R5 boot vector", redirect_pc, 32'hBFC0_0380);
    chk("R2 epc slot", epc_o, 32'h0000_0FFC);
    chk("R2 R4 cause", cause_o, 32'h8000_0010);
    chk("R4 exl", 32'(exl_o), 1);
    chk("R4 user", 32'(user_o), 0);
    @(negedge clk);
    chk("R1 strobe drop", 32'(redirect_valid), 0);
  endtask

  task automatic t_nested;
    raise(3'd0, 5'd8, 32'h0000_2000, 0);
    chk("R3 epc kept", epc_o, 32'h0000_0FFC);
    chk("R3 R4 bd kept code new", cause_o, 32'h8000_0020);
    raise(3'd1, 5'd2, 32'h0000_3000, 0);
    chk("R6 refill exl set", redirect_pc, 32'hBFC0_0380);
    chk("R3 refill epc kept", epc_o, 32'h0000_0FFC);
  endtask

  task automatic t_refill_ram;
    sw_write(0, 0, 0, 0);
    raise(3'd1, 5'd3, 32'h0000_4000, 0);
    chk("R6 refill exl clear", redirect_pc, 32'h8000_0000);
    chk("R2 epc no slot", epc_o, 32'h0000_4000);
    chk("R2 R4 cause", cause_o, 32'h0000_000C);
  endtask

  task automatic t_irq;
    sw_write(0, 0, 0, 0);
    cfg_irq_vec = 1;
    raise(3'd0, 5'd0, 32'h0000_5000, 0);
    chk("R7 irq special", redirect_pc, 32'h8000_0380);
    sw_write(0, 0, 0, 0);
    cfg_irq_vec = 0;
    raise(3'd0, 5'd0, 32'h0000_5100, 0);
    chk("R7 R5 irq plain", redirect_pc, 32'h8000_0180);
    chk("R2 epc", epc_o, 32'h0000_5100);
  endtask

  task automatic t_write_loses;
    sw_write(0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; req_kind = 3'd0; req_code = 5'd10; req_pc = 32'h0000_5200;
    sw_we = 1; sw_exl = 0; sw_um = 1; sw_bev = 1;
    @(negedge clk);
    req_valid = 0; sw_we = 0;
    chk("R10 exl ignored", 32'(exl_o), 1);
    chk("R10 user ignored", 32'(user_o), 0);
    chk("R10 bev ignored", 32'(bev_o), 0);
    chk("R4 code", 32'(cause_o[6:2]), 10);
  endtask

  task automatic t_soft_reset;
    keep_epc = epc_o; keep_cause = cause_o;
    sw_write(1, 0, 0, 1);
    raise(3'd2, 5'd0, 32'h0000_6000, 1);
    chk("R8 error epc", error_epc_o, 32'h0000_5FFC);
    chk("R8 erl", 32'(erl_o), 1);
    chk("R8 bev", 32'(bev_o), 1);
    chk("R8 sr", 32'(sr_o), 1);
    chk("R8 nmi", 32'(nmi_o), 0);
    chk("R8 user", 32'(user_o), 0);
    chk("R8 vector", redirect_pc, 32'hBFC0_0000);
    chk("R8 watch", 32'(watch_clr_o), 1);
    chk("R12 epc", epc_o, keep_epc);
    chk("R12 cause", cause_o, keep_cause);
    @(negedge clk);
    chk("R8 watch drop", 32'(watch_clr_o), 0);
  endtask

  task automatic t_nmi;
    raise(3'd3, 5'd0, 32'h0000_7000, 0);
    chk("R8 nmi epc", error_epc_o, 32'h0000_7000);
    chk("R8 nmi bit", 32'(nmi_o), 1);
    chk("R8 nmi vector", redirect_pc, 32'hBFC0_0000);
    chk("R8 no watch", 32'(watch_clr_o), 0);
  endtask

  task automatic t_debug;
    keep_epc = epc_o; keep_cause = cause_o;
    sw_write(1, 0, 1, 1);
    raise(3'd4, 5'd0, 32'h0000_8000, 1);
    chk("R9 depc", depc_o, 32'h0000_7FFC);
    chk("R9 dm", 32'(debug_o), 1);
    chk("R9 user", 32'(user_o), 0);
    chk("R9 vector", redirect_pc, 32'hBFC0_0480);
    chk("R12 dbg epc", epc_o, keep_epc);
    chk("R12 dbg cause", cause_o, keep_cause);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_kind = 3'd0; req_code = 5'd1; req_pc = 32'h0000_9000;
    @(negedge clk);
    chk("R1 first", 32'(redirect_valid), 1);
    @(negedge clk);
    req_valid = 0;
    chk("R1 second", 32'(redirect_valid), 1);
    @(negedge clk);
    chk("R1 idle", 32'(redirect_valid), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_status_write();
        t_first_entry();
        t_nested();
        t_refill_ram();
        t_irq();
        t_write_loses();
        t_soft_reset();
        t_nmi();
        t_debug();
        t_back_to_back();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule